// File: doc/BRIEF.md
# JPEG Marker Stream Parser

This block reads a compressed still-image file one byte per accepted cycle after a start pulse. It first checks for the start-of-image marker. It then walks the marker segments that follow and uses each segment's length field to know where the segment ends. Quantization and Huffman table contents go out on a single table write port to the decoder's table memories. Frame geometry, component sampling factors, quantization table choices and scan table selectors are held in output registers.

When the last header byte of the scan segment has been consumed, the parser enters scan mode. From then on it forwards every accepted byte, unchanged, to the entropy decoder. Any malformed or unsupported construct stops the parser and reports a two-bit error code. The code and every captured register keep their values until the next start pulse.

Top module: `jmp_parser`

## Requirements
- R1: A start pulse clears every captured register, the error code, scan mode and both output strobes. The parser then expects the image-start marker. Error code values: 0 none, 1 missing image-start marker, 2 non-baseline frame, 3 format error.
- R2: If the first two accepted bytes after start are not 0xFF then 0xD8, errCode becomes 1. Once raised, an error holds its code and blocks further table writes until the next start pulse.
- R3: After each segment the parser expects 0xFF. Any further 0xFF fill bytes before the marker code are skipped. Any other byte where 0xFF is expected gives errCode 3.
- R4: Each segment length is 16 bits, most significant byte first, and counts the two length bytes. A length below 2 gives errCode 3. Segments the parser does not use (application, comment and any other marker with a length) are skipped with no table write.
- R5: A quantization segment (code 0xDB) holds one or more tables. Each table is a header byte (precision nibble in bits 7:4, which must be 0, otherwise errCode 3; id in bits 1:0) and 64 values. Each value is written with tblSel=0 and tblAddr = id*64 + index, in stream order.
- R6: A Huffman segment (code 0xC4) holds one or more tables. Each table is a header byte (class in bits 7:4, which must be 0 or 1; id in bits 3:0, which must be below 4) followed by 16 counts and then as many symbols as the counts add up to. Every byte after the header is written with tblSel=1 and tblAddr = class*2048 + id*512 + index: counts at index 0..15, symbols from index 16. A count total above 256 gives errCode 3.
- R7: A baseline frame segment (code 0xC0) must have precision 8 and a component count of 1 or 3, otherwise errCode 3. It loads imgHeight and imgWidth. For component k it loads compSampling[8k+7:8k] (horizontal factor in the high nibble) and compQtId[2k+1:2k].
- R8: Accepted sampling is a single component with factor byte 0x11, or three components where the first is 0x11, 0x21 or 0x22 and the other two are 0x11. Anything else gives errCode 3.
- R9: Marker codes 0xC1 to 0xCF, other than 0xC4, give errCode 2.
- R10: A scan segment (code 0xDA) loads scanCount and, per scan component k, scanCompId[8k+7:8k] and scanHuffSel[8k+7:8k] (DC table id high nibble, AC table id low nibble). After its last byte, scanActive is 1. Each later accepted byte, including 0xFF, appears on ecsByte with ecsValid one cycle later, and no table write occurs.
- R11: A byte presented with inValid low has no effect.
- R12: Marker code 0xD9, 0xD8 or 0x00 before the scan gives errCode 3. Marker codes 0xD0 to 0xD7 and 0x01 carry no length and are passed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Begins parsing a new file |
| inValid | input | 1 | inByte holds a stream byte this cycle |
| inByte | input | 8 | Stream byte |
| errFlag | output | 1 | Error code is non-zero |
| errCode | output | 2 | Error code |
| scanActive | output | 1 | Parser is forwarding entropy-coded bytes |
| ecsValid | output | 1 | ecsByte is valid |
| ecsByte | output | 8 | Forwarded entropy-coded byte |
| tblWe | output | 1 | Table memory write strobe |
| tblSel | output | 1 | 0 quantization memory, 1 Huffman memory |
| tblAddr | output | 12 | Table memory address |
| tblData | output | 8 | Table memory data |
| imgWidth | output | 16 | Frame width in samples |
| imgHeight | output | 16 | Frame height in lines |
| compCount | output | 2 | Frame component count |
| compSampling | output | 24 | Sampling factor byte per component |
| compQtId | output | 6 | Quantization table id per component |
| scanCount | output | 2 | Scan component count |
| scanCompId | output | 24 | Component selector per scan component |
| scanHuffSel | output | 24 | Huffman table selectors per scan component |

## Verification
The assertions check the cycle-level rules on every cycle. An idle input leaves the control quiet. At most one load action happens per byte. A segment never reads past its own length. An error holds until the next start pulse and is followed by no table write. In scan mode, no table write occurs and every accepted byte is forwarded one cycle later. The bench scenarios cover what needs a whole stream to see: the exact addresses and order of table writes, the captured frame and scan fields, fill bytes and skipped segments, and which error code each malformed or unsupported stream produces.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
  localparam int MAX_COMP    = 3;
  localparam int COMP_CNT_W  = 2;
  localparam int QT_ID_W     = 2;
  localparam int HT_ID_W     = 2;
  localparam int QT_IDX_W    = 6;
  localparam int QT_LEN      = 64;
  localparam int HT_NCOUNT   = 16;
  localparam int HT_MAX_SYM  = 256;
  localparam int HT_IDX_W    = 9;
  localparam int TBL_ADDR_W  = 1 + HT_ID_W + HT_IDX_W;
  localparam int TBL_LEN_W   = 13;
  localparam int SEG_LEN_W   = 16;
  localparam int POS_W       = 8;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_NO_SOI = 2'd1,
    ERR_FRAME  = 2'd2,
    ERR_FORMAT = 2'd3
  } errCode_t;

  typedef enum logic [2:0] {
    SEG_SKIP, SEG_DQT, SEG_DHT, SEG_SOF, SEG_SOS
  } segKind_t;

  typedef struct packed {
    logic clearAll;
    logic lenHi;
    logic lenLo;
    logic bodyByte;
    logic qtHdr;
    logic qtByte;
    logic htHdr;
    logic htByte;
    logic sofByte;
    logic sosByte;
    logic passByte;
  } dpStrobe_t;
endpackage

// File: rtl/jmp_ctrl.sv
module jmp_ctrl
  import jmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       lenShort,
  input  logic       bodyEmpty,
  input  logic       lastBody,
  input  logic       tableLast,
  input  logic       qtHdrBad,
  input  logic       htHdrBad,
  input  logic       htCountBad,
  input  logic       sofBad,
  input  logic       sosBad,
  output dpStrobe_t  stb,
  output logic [1:0] errCode,
  output logic       scanActive
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_SOI0, ST_SOI1, ST_MFF, ST_MCODE,
    ST_LENH, ST_LENL, ST_BODY, ST_SCAN, ST_ERR
  } state_t;

  state_t   state, nextState;
  segKind_t segKind, nextKind;
  logic     tblData, nextTblData;
  errCode_t errReg, nextErr;
  logic     byteBad;

  always_comb begin
    byteBad = 1'b0;
    case (segKind)
      SEG_DQT: byteBad = !tblData && qtHdrBad;
      SEG_DHT: byteBad = tblData ? htCountBad : htHdrBad;
      SEG_SOF: byteBad = sofBad;
      SEG_SOS: byteBad = sosBad;
      default: byteBad = 1'b0;
    endcase
  end

  always_comb begin
    stb         = '0;
    nextState   = state;
    nextKind    = segKind;
    nextTblData = tblData;
    nextErr     = errReg;
    if (startPulse) begin
      stb.clearAll = 1'b1;
      nextState    = ST_SOI0;
      nextKind     = SEG_SKIP;
      nextTblData  = 1'b0;
      nextErr      = ERR_NONE;
    end else if (inValid) begin
      case (state)
        ST_SOI0: begin
          if (inByte == 8'hFF) nextState = ST_SOI1;
          else begin nextState = ST_ERR; nextErr = ERR_NO_SOI; end
        end
        ST_SOI1: begin
          if (inByte == 8'hD8) nextState = ST_MFF;
          else begin nextState = ST_ERR; nextErr = ERR_NO_SOI; end
        end
        ST_MFF: begin
          if (inByte == 8'hFF) nextState = ST_MCODE;
          else begin nextState = ST_ERR; nextErr = ERR_FORMAT; end
        end
        ST_MCODE: begin
          if (inByte == 8'hFF) begin
            nextState = ST_MCODE;
          end else if (inByte == 8'hC0) begin
            nextKind = SEG_SOF; nextState = ST_LENH;
          end else if (inByte == 8'hC4) begin
            nextKind = SEG_DHT; nextState = ST_LENH;
          end else if (inByte == 8'hDB) begin
            nextKind = SEG_DQT; nextState = ST_LENH;
          end else if (inByte == 8'hDA) begin
            nextKind = SEG_SOS; nextState = ST_LENH;
          end else if (inByte[7:4] == 4'hC) begin
            nextState = ST_ERR; nextErr = ERR_FRAME;
          end else if (inByte == 8'hD9 || inByte == 8'hD8 || inByte == 8'h00) begin
            nextState = ST_ERR; nextErr = ERR_FORMAT;
          end else if (inByte[7:3] == 5'b11010 || inByte == 8'h01) begin
            nextState = ST_MFF;
          end else begin
            nextKind = SEG_SKIP; nextState = ST_LENH;
          end
        end
        ST_LENH: begin
          stb.lenHi = 1'b1;
          nextState = ST_LENL;
        end
        ST_LENL: begin
          stb.lenLo   = 1'b1;
          nextTblData = 1'b0;
          if (lenShort) begin
            nextState = ST_ERR; nextErr = ERR_FORMAT;
          end else if (bodyEmpty) begin
            nextState = (segKind == SEG_SOS) ? ST_SCAN : ST_MFF;
          end else begin
            nextState = ST_BODY;
          end
        end
        ST_BODY: begin
          stb.bodyByte = 1'b1;
          case (segKind)
            SEG_DQT: begin
              if (tblData) begin
                stb.qtByte = 1'b1;
                if (tableLast) nextTblData = 1'b0;
              end else begin
                stb.qtHdr   = 1'b1;
                nextTblData = 1'b1;
              end
            end
            SEG_DHT: begin
              if (tblData) begin
                stb.htByte = 1'b1;
                if (tableLast) nextTblData = 1'b0;
              end else begin
                stb.htHdr   = 1'b1;
                nextTblData = 1'b1;
              end
            end
            SEG_SOF: stb.sofByte = 1'b1;
            SEG_SOS: stb.sosByte = 1'b1;
            default: ;
          endcase
          if (byteBad) begin
            nextState = ST_ERR; nextErr = ERR_FORMAT;
          end else if (lastBody) begin
            nextState   = (segKind == SEG_SOS) ? ST_SCAN : ST_MFF;
            nextTblData = 1'b0;
          end
        end
        ST_SCAN: stb.passByte = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      segKind <= SEG_SKIP;
      tblData <= 1'b0;
      errReg  <= ERR_NONE;
    end else begin
      state   <= nextState;
      segKind <= nextKind;
      tblData <= nextTblData;
      errReg  <= nextErr;
    end
  end

  assign errCode    = errReg;
  assign scanActive = (state == ST_SCAN);

  p_idle_no_action_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !startPulse) |-> (stb == '0));

  p_one_action_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.lenHi, stb.lenLo, stb.qtHdr, stb.qtByte, stb.htHdr,
              stb.htByte, stb.sofByte, stb.sosByte, stb.passByte}));
endmodule

// File: rtl/jmp_datapath.sv
module jmp_datapath
  import jmp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                stb,
  input  logic [7:0]               inByte,
  output logic                     lenShort,
  output logic                     bodyEmpty,
  output logic                     lastBody,
  output logic                     tableLast,
  output logic                     qtHdrBad,
  output logic                     htHdrBad,
  output logic                     htCountBad,
  output logic                     sofBad,
  output logic                     sosBad,
  output logic                     ecsValid,
  output logic [7:0]               ecsByte,
  output logic                     tblWe,
  output logic                     tblSel,
  output logic [TBL_ADDR_W-1:0]    tblAddr,
  output logic [7:0]               tblData,
  output logic [15:0]              imgWidth,
  output logic [15:0]              imgHeight,
  output logic [COMP_CNT_W-1:0]    compCount,
  output logic [8*MAX_COMP-1:0]    compSampling,
  output logic [QT_ID_W*MAX_COMP-1:0] compQtId,
  output logic [COMP_CNT_W-1:0]    scanCount,
  output logic [8*MAX_COMP-1:0]    scanCompId,
  output logic [8*MAX_COMP-1:0]    scanHuffSel
);
  localparam int QT_PAD_W = TBL_ADDR_W - QT_ID_W - QT_IDX_W;
  localparam logic [TBL_LEN_W-1:0] HT_LEN_MAX = TBL_LEN_W'(HT_NCOUNT + HT_MAX_SYM);

  logic [7:0]            lenHiReg;
  logic [SEG_LEN_W-1:0]  remain;
  logic [POS_W-1:0]      segPos;
  logic [1:0]            fieldCnt;
  logic [COMP_CNT_W-1:0] compIdx;
  logic [HT_ID_W-1:0]    tblId;
  logic                  tblClass;
  logic                  tblIsHuff;
  logic [HT_IDX_W-1:0]   tblIdx;
  logic [TBL_LEN_W-1:0]  tblLen;
  logic [TBL_LEN_W-1:0]  lenEff;
  logic [SEG_LEN_W-1:0]  fullLen;
  logic                  inCounts;
  logic                  hvOk;

  assign fullLen   = {lenHiReg, inByte};
  assign lenShort  = fullLen < SEG_LEN_W'(2);
  assign bodyEmpty = fullLen == SEG_LEN_W'(2);
  assign lastBody  = remain == SEG_LEN_W'(1);

  assign inCounts   = tblIsHuff && (tblIdx < HT_IDX_W'(HT_NCOUNT));
  assign lenEff     = inCounts ? tblLen + TBL_LEN_W'(inByte) : tblLen;
  assign tableLast  = (TBL_LEN_W'(tblIdx) + TBL_LEN_W'(1)) == lenEff;
  assign htCountBad = tblIsHuff && (tblIdx == HT_IDX_W'(HT_NCOUNT - 1)) && (lenEff > HT_LEN_MAX);
  assign qtHdrBad   = (inByte[7:4] != 4'd0) || (inByte[3:0] > 4'((1 << QT_ID_W) - 1));
  assign htHdrBad   = (inByte[7:4] > 4'd1) || (inByte[3:0] > 4'((1 << HT_ID_W) - 1));

  always_comb begin
    if (compIdx != '0)        hvOk = (inByte == 8'h11);
    else if (compCount == 2'd1) hvOk = (inByte == 8'h11);
    else hvOk = (inByte == 8'h11) || (inByte == 8'h21) || (inByte == 8'h22);
  end

  always_comb begin
    sofBad = 1'b0;
    if (segPos == POS_W'(0))      sofBad = (inByte != 8'd8);
    else if (segPos == POS_W'(5)) sofBad = !((inByte == 8'd1) || (inByte == 8'd3));
    else if (segPos >= POS_W'(6) && fieldCnt == 2'd1 && compIdx < COMP_CNT_W'(MAX_COMP))
      sofBad = !hvOk;
  end

  assign sosBad = (segPos == POS_W'(0)) && ((inByte == 8'd0) || (inByte > 8'(MAX_COMP)));

  // segment walking state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenHiReg <= '0; remain <= '0; segPos <= '0; fieldCnt <= '0; compIdx <= '0;
    end else if (stb.clearAll) begin
      lenHiReg <= '0; remain <= '0; segPos <= '0; fieldCnt <= '0; compIdx <= '0;
    end else begin
      if (stb.lenHi) lenHiReg <= inByte;
      if (stb.lenLo) begin
        remain   <= fullLen - SEG_LEN_W'(2);
        segPos   <= '0;
        fieldCnt <= '0;
        compIdx  <= '0;
      end
      if (stb.bodyByte) begin
        remain <= remain - SEG_LEN_W'(1);
        if (segPos != '1) segPos <= segPos + POS_W'(1);
      end
      if (stb.sofByte && segPos >= POS_W'(6)) begin
        if (fieldCnt == 2'd2) begin
          fieldCnt <= '0;
          if (compIdx < COMP_CNT_W'(MAX_COMP)) compIdx <= compIdx + COMP_CNT_W'(1);
        end else fieldCnt <= fieldCnt + 2'd1;
      end
      if (stb.sosByte && segPos >= POS_W'(1)) begin
        if (fieldCnt == 2'd1) begin
          fieldCnt <= '0;
          if (compIdx < COMP_CNT_W'(MAX_COMP)) compIdx <= compIdx + COMP_CNT_W'(1);
        end else fieldCnt <= fieldCnt + 2'd1;
      end
    end
  end

  // table loading
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tblId <= '0; tblClass <= 1'b0; tblIsHuff <= 1'b0; tblIdx <= '0; tblLen <= '0;
      tblWe <= 1'b0; tblSel <= 1'b0; tblAddr <= '0; tblData <= '0;
    end else begin
      tblWe <= 1'b0;
      if (stb.clearAll) begin
        tblId <= '0; tblClass <= 1'b0; tblIsHuff <= 1'b0; tblIdx <= '0; tblLen <= '0;
        tblSel <= 1'b0; tblAddr <= '0; tblData <= '0;
      end else if (stb.qtHdr) begin
        tblId     <= inByte[QT_ID_W-1:0];
        tblIsHuff <= 1'b0;
        tblIdx    <= '0;
        tblLen    <= TBL_LEN_W'(QT_LEN);
      end else if (stb.htHdr) begin
        tblId     <= inByte[HT_ID_W-1:0];
        tblClass  <= inByte[4];
        tblIsHuff <= 1'b1;
        tblIdx    <= '0;
        tblLen    <= TBL_LEN_W'(HT_NCOUNT);
      end else if (stb.qtByte) begin
        tblWe   <= 1'b1;
        tblSel  <= 1'b0;
        tblAddr <= {{QT_PAD_W{1'b0}}, tblId[QT_ID_W-1:0], tblIdx[QT_IDX_W-1:0]};
        tblData <= inByte;
        tblIdx  <= tblIdx + HT_IDX_W'(1);
      end else if (stb.htByte) begin
        tblWe   <= 1'b1;
        tblSel  <= 1'b1;
        tblAddr <= {tblClass, tblId, tblIdx};
        tblData <= inByte;
        tblIdx  <= tblIdx + HT_IDX_W'(1);
        tblLen  <= lenEff;
      end
    end
  end

  // frame and scan registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      imgWidth <= '0; imgHeight <= '0; compCount <= '0; compSampling <= '0; compQtId <= '0;
      scanCount <= '0; scanCompId <= '0; scanHuffSel <= '0;
    end else if (stb.clearAll) begin
      imgWidth <= '0; imgHeight <= '0; compCount <= '0; compSampling <= '0; compQtId <= '0;
      scanCount <= '0; scanCompId <= '0; scanHuffSel <= '0;
    end else if (stb.sofByte) begin
      case (segPos)
        POS_W'(1): imgHeight[15:8] <= inByte;
        POS_W'(2): imgHeight[7:0]  <= inByte;
        POS_W'(3): imgWidth[15:8]  <= inByte;
        POS_W'(4): imgWidth[7:0]   <= inByte;
        POS_W'(5): compCount       <= inByte[COMP_CNT_W-1:0];
        default: begin
          for (int k = 0; k < MAX_COMP; k++) begin
            if (segPos >= POS_W'(6) && compIdx == COMP_CNT_W'(k)) begin
              if (fieldCnt == 2'd1) compSampling[8*k +: 8] <= inByte;
              if (fieldCnt == 2'd2) compQtId[QT_ID_W*k +: QT_ID_W] <= inByte[QT_ID_W-1:0];
            end
          end
        end
      endcase
    end else if (stb.sosByte) begin
      if (segPos == POS_W'(0)) scanCount <= inByte[COMP_CNT_W-1:0];
      else begin
        for (int k = 0; k < MAX_COMP; k++) begin
          if (compIdx == COMP_CNT_W'(k) && compIdx < scanCount) begin
            if (fieldCnt == 2'd0) scanCompId[8*k +: 8]  <= inByte;
            else                  scanHuffSel[8*k +: 8] <= inByte;
          end
        end
      end
    end
  end

  // entropy-coded byte forwarding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ecsValid <= 1'b0; ecsByte <= '0;
    end else begin
      ecsValid <= stb.passByte;
      if (stb.clearAll)      ecsByte <= '0;
      else if (stb.passByte) ecsByte <= inByte;
    end
  end

  p_body_in_bounds_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.bodyByte |-> (remain != '0));
endmodule

// File: rtl/jmp_parser.sv
module jmp_parser
  import jmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  output logic        errFlag,
  output logic [1:0]  errCode,
  output logic        scanActive,
  output logic        ecsValid,
  output logic [7:0]  ecsByte,
  output logic        tblWe,
  output logic        tblSel,
  output logic [11:0] tblAddr,
  output logic [7:0]  tblData,
  output logic [15:0] imgWidth,
  output logic [15:0] imgHeight,
  output logic [1:0]  compCount,
  output logic [23:0] compSampling,
  output logic [5:0]  compQtId,
  output logic [1:0]  scanCount,
  output logic [23:0] scanCompId,
  output logic [23:0] scanHuffSel
);
  dpStrobe_t stb;
  logic lenShort, bodyEmpty, lastBody, tableLast;
  logic qtHdrBad, htHdrBad, htCountBad, sofBad, sosBad;

  jmp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .inValid(inValid), .inByte(inByte),
    .lenShort(lenShort), .bodyEmpty(bodyEmpty), .lastBody(lastBody), .tableLast(tableLast),
    .qtHdrBad(qtHdrBad), .htHdrBad(htHdrBad), .htCountBad(htCountBad),
    .sofBad(sofBad), .sosBad(sosBad),
    .stb(stb), .errCode(errCode), .scanActive(scanActive)
  );

  jmp_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .inByte(inByte),
    .lenShort(lenShort), .bodyEmpty(bodyEmpty), .lastBody(lastBody), .tableLast(tableLast),
    .qtHdrBad(qtHdrBad), .htHdrBad(htHdrBad), .htCountBad(htCountBad),
    .sofBad(sofBad), .sosBad(sosBad),
    .ecsValid(ecsValid), .ecsByte(ecsByte),
    .tblWe(tblWe), .tblSel(tblSel), .tblAddr(tblAddr), .tblData(tblData),
    .imgWidth(imgWidth), .imgHeight(imgHeight), .compCount(compCount),
    .compSampling(compSampling), .compQtId(compQtId),
    .scanCount(scanCount), .scanCompId(scanCompId), .scanHuffSel(scanHuffSel)
  );

  assign errFlag = (errCode != 2'd0);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !startPulse) |=> (errFlag && $stable(errCode)));

  p_no_write_after_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && $past(errFlag)) |-> !tblWe);

  p_scan_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (scanActive && $past(scanActive)) |-> !tblWe);

  p_ecs_forward_r10: assert property (@(posedge clk) disable iff (!rstN)
    (scanActive && inValid && !startPulse) |=> (ecsValid && ecsByte == $past(inByte)));

  p_ecs_only_in_scan_r10: assert property (@(posedge clk) disable iff (!rstN)
    ecsValid |-> scanActive);
endmodule

// File: tb/jmp_parser_tb.sv
module jmp_parser_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        errFlag, scanActive, ecsValid, tblWe, tblSel;
  logic [1:0]  errCode, compCount, scanCount;
  logic [7:0]  ecsByte, tblData;
  logic [11:0] tblAddr;
  logic [15:0] imgWidth, imgHeight;
  logic [23:0] compSampling, scanCompId, scanHuffSel;
  logic [5:0]  compQtId;

  int checks = 0;
  int failures = 0;
  int byteNo = 0;
  bit finished = 0;
  logic [20:0] expWr[$];
  logic [7:0]  expEcs[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  jmp_parser dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .inValid(inValid), .inByte(inByte),
    .errFlag(errFlag), .errCode(errCode), .scanActive(scanActive),
    .ecsValid(ecsValid), .ecsByte(ecsByte),
    .tblWe(tblWe), .tblSel(tblSel), .tblAddr(tblAddr), .tblData(tblData),
    .imgWidth(imgWidth), .imgHeight(imgHeight), .compCount(compCount),
    .compSampling(compSampling), .compQtId(compQtId),
    .scanCount(scanCount), .scanCompId(scanCompId), .scanHuffSel(scanHuffSel)
  );

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one byte; every fifth byte is preceded by an idle cycle carrying junk (R11)
  task automatic sendByte(logic [7:0] b);
    byteNo++;
    if (byteNo % 5 == 0) begin
      @(negedge clk); inValid = 1'b0; inByte = 8'hFF;
    end
    @(negedge clk); inValid = 1'b1; inByte = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); inValid = 1'b0; inByte = 8'h00;
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); inValid = 1'b0; startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
  endtask

  task automatic sendQtTable(logic [1:0] id, logic [7:0] base);
    sendByte({6'd0, id});
    for (int i = 0; i < 64; i++) begin
      expWr.push_back({1'b0, 4'd0, id, 6'(i), 8'(base + 8'(i * 3))});
      sendByte(8'(base + 8'(i * 3)));
    end
  endtask

  task automatic expHt(logic cls, logic [1:0] id, int idx, logic [7:0] v);
    expWr.push_back({1'b1, cls, id, 9'(idx), v});
  endtask

  // scoreboard monitor: table writes and forwarded bytes
  always @(negedge clk) begin
    if (rstN && tblWe) begin
      checks++;
      if (expWr.size() == 0) begin
        failures++;
        $display("FAIL R4/R5/R6 unexpected write actual=%0h expected=none", {tblSel, tblAddr, tblData});
      end else begin
        logic [20:0] e;
        e = expWr.pop_front();
        if ({tblSel, tblAddr, tblData} !== e) begin
          failures++;
          $display("FAIL %s write actual=%0h expected=%0h", e[20] ? "R6" : "R5",
                   {tblSel, tblAddr, tblData}, e);
        end
      end
    end
    if (rstN && ecsValid) begin
      checks++;
      if (expEcs.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected ecs byte actual=%0h expected=none", ecsByte);
      end else begin
        logic [7:0] e2;
        e2 = expEcs.pop_front();
        if (ecsByte !== e2) begin
          failures++;
          $display("FAIL R10 ecs byte actual=%0h expected=%0h", ecsByte, e2);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    checkEq("R1 errCode after reset", errCode, 0);
    checkEq("R1 scanActive after reset", scanActive, 0);
    checkEq("R1 width after reset", imgWidth, 0);

    // R2: bad image-start marker
    pulseStart();
    sendByte(8'hFF); sendByte(8'hD9); idle(1);
    checkEq("R2 missing SOI code", errCode, 1);
    sendByte(8'hFF); sendByte(8'hD8); sendByte(8'hFF); sendByte(8'hDB); idle(1);
    checkEq("R2 error sticky", errCode, 1);

    // full colour stream
    pulseStart();
    checkEq("R1 start clears error", errCode, 0);
    sendByte(8'hFF); sendByte(8'hD8);
    // R3 fill bytes, R4 skipped application segment
    sendByte(8'hFF); sendByte(8'hFF); sendByte(8'hFF); sendByte(8'hE0);
    sendByte(8'h00); sendByte(8'h06);
    sendByte(8'hFF); sendByte(8'hC4); sendByte(8'hDB); sendByte(8'h12);
    // R5: two quantization tables in one segment, length 132
    sendByte(8'hFF); sendByte(8'hDB); sendByte(8'h00); sendByte(8'h84);
    sendQtTable(2'd0, 8'h10);
    sendQtTable(2'd1, 8'h05);
    // R6: AC table 0 then DC table 1, length 40
    sendByte(8'hFF); sendByte(8'hC4); sendByte(8'h00); sendByte(8'd40);
    sendByte(8'h10);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c;
      c = (i == 1) ? 8'd2 : (i == 2) ? 8'd1 : 8'd0;
      expHt(1'b1, 2'd0, i, c);
      sendByte(c);
    end
    for (int i = 0; i < 3; i++) begin
      expHt(1'b1, 2'd0, 16 + i, 8'(i + 1));
      sendByte(8'(i + 1));
    end
    sendByte(8'h01);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c;
      c = (i == 0) ? 8'd1 : 8'd0;
      expHt(1'b0, 2'd1, i, c);
      sendByte(c);
    end
    expHt(1'b0, 2'd1, 16, 8'h05);
    sendByte(8'h05);
    // R7/R8: frame 48x32, three components, 4:2:0
    sendByte(8'hFF); sendByte(8'hC0); sendByte(8'h00); sendByte(8'd17);
    sendByte(8'h08); sendByte(8'h00); sendByte(8'h20); sendByte(8'h00); sendByte(8'h30);
    sendByte(8'h03);
    sendByte(8'h01); sendByte(8'h22); sendByte(8'h00);
    sendByte(8'h02); sendByte(8'h11); sendByte(8'h01);
    sendByte(8'h03); sendByte(8'h11); sendByte(8'h01);
    // R10: scan header
    sendByte(8'hFF); sendByte(8'hDA); sendByte(8'h00); sendByte(8'd12);
    sendByte(8'h03);
    sendByte(8'h01); sendByte(8'h00);
    sendByte(8'h02); sendByte(8'h11);
    sendByte(8'h03); sendByte(8'h11);
    sendByte(8'h00); sendByte(8'h3F); sendByte(8'h00);
    idle(1);
    checkEq("R10 scanActive after scan header", scanActive, 1);
    checkEq("R7 height", imgHeight, 16'h20);
    checkEq("R7 width", imgWidth, 16'h30);
    checkEq("R7 compCount", compCount, 3);
    checkEq("R7 R8 compSampling", compSampling, 24'h111122);
    checkEq("R7 compQtId", compQtId, 6'h14);
    checkEq("R10 scanCount", scanCount, 3);
    checkEq("R10 scanCompId", scanCompId, 24'h030201);
    checkEq("R10 scanHuffSel", scanHuffSel, 24'h111100);
    checkEq("R5 R6 all writes seen", expWr.size(), 0);
    // R10 forwarding including 0xFF
    begin
      logic [7:0] ecsData [5];
      ecsData = '{8'h12, 8'h34, 8'hFF, 8'h00, 8'hD9};
      foreach (ecsData[i]) begin
        expEcs.push_back(ecsData[i]);
        sendByte(ecsData[i]);
      end
    end
    idle(2);
    checkEq("R10 all ecs bytes seen", expEcs.size(), 0);
    checkEq("R10 no error in scan", errCode, 0);

    // R1 start clears captured registers
    pulseStart();
    checkEq("R1 width cleared", imgWidth, 0);
    checkEq("R1 sampling cleared", compSampling, 0);
    checkEq("R1 scanActive cleared", scanActive, 0);

    // R9 progressive frame
    sendByte(8'hFF); sendByte(8'hD8); sendByte(8'hFF); sendByte(8'hC2); idle(1);
    checkEq("R9 non-baseline frame", errCode, 2);

    // R8 bad sampling (0x12)
    pulseStart();
    sendByte(8'hFF); sendByte(8'hD8);
    sendByte(8'hFF); sendByte(8'hC0); sendByte(8'h00); sendByte(8'd17);
    sendByte(8'h08); sendByte(8'h00); sendByte(8'h08); sendByte(8'h00); sendByte(8'h08);
    sendByte(8'h03); sendByte(8'h01); sendByte(8'h12); idle(1);
    checkEq("R8 sampling 0x12 rejected", errCode, 3);

    // R12 restart marker passed over, R8 grayscale accepted, then early end marker
    pulseStart();
    sendByte(8'hFF); sendByte(8'hD8); sendByte(8'hFF); sendByte(8'hD3);
    sendByte(8'hFF); sendByte(8'hC0); sendByte(8'h00); sendByte(8'd11);
    sendByte(8'h08); sendByte(8'h00); sendByte(8'h10); sendByte(8'h00); sendByte(8'h18);
    sendByte(8'h01); sendByte(8'h01); sendByte(8'h11); sendByte(8'h02);
    idle(1);
    checkEq("R12 restart marker skipped", errCode, 0);
    checkEq("R8 gray compCount", compCount, 1);
    checkEq("R7 gray width", imgWidth, 16'h18);
    checkEq("R7 gray qt id", compQtId, 6'h02);
    sendByte(8'hFF); sendByte(8'hD9); idle(1);
    checkEq("R12 end marker before scan", errCode, 3);

    // R3/R4: comment skipped, then a non-0xFF byte where a marker is due
    pulseStart();
    sendByte(8'hFF); sendByte(8'hD8);
    sendByte(8'hFF); sendByte(8'hFE); sendByte(8'h00); sendByte(8'h04);
    sendByte(8'hFF); sendByte(8'hDB); idle(1);
    checkEq("R4 comment skipped", errCode, 0);
    sendByte(8'h12); idle(1);
    checkEq("R3 missing marker prefix", errCode, 3);

    // R4 short length
    pulseStart();
    sendByte(8'hFF); sendByte(8'hD8); sendByte(8'hFF); sendByte(8'hE1);
    sendByte(8'h00); sendByte(8'h01); idle(1);
    checkEq("R4 length below 2", errCode, 3);

    // R5 16-bit precision rejected
    pulseStart();
    sendByte(8'hFF); sendByte(8'hD8); sendByte(8'hFF); sendByte(8'hDB);
    sendByte(8'h00); sendByte(8'h43); sendByte(8'h10); idle(1);
    checkEq("R5 precision nibble rejected", errCode, 3);

    // R6 count total above 256
    pulseStart();
    sendByte(8'hFF); sendByte(8'hD8); sendByte(8'hFF); sendByte(8'hC4);
    sendByte(8'h01); sendByte(8'h00); sendByte(8'h00);
    for (int i = 0; i < 16; i++) begin
      expHt(1'b0, 2'd0, i, 8'hFF);
      sendByte(8'hFF);
    end
    sendByte(8'h01); sendByte(8'h02);
    idle(2);
    checkEq("R6 count overflow", errCode, 3);
    checkEq("R6 overflow writes", expWr.size(), 0);

    // R11: idle inputs leave error-free state untouched
    pulseStart();
    idle(4);
    checkEq("R11 idle no error", errCode, 0);
    sendByte(8'hFF); sendByte(8'hD8); idle(1);
    checkEq("R11 SOI accepted around gaps", errCode, 0);

    idle(3);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule